// File: doc/BRIEF.md
# Digest Input Descriptor Ring Fetcher

This block is the front end of one channel of a message-digest engine. Software places 16-byte input descriptors in a ring of 127 slots in memory, starting at a programmable 64-bit base address. It then advances a write index by writing the channel configuration. The fetcher compares its own read index with that write index. For each pending slot it reads the four descriptor words over a single-outstanding memory read port and decodes the message address, the byte length and the framing flags. It then hands a burst request to the digest datapath.

Each descriptor carries two framing flags, "opens a message" and "closes a message", so one message can span several descriptors. The length of each descriptor is checked against the block size of the selected algorithm. A descriptor that fails the check is dropped and reported on a one-cycle error output. Completed descriptors are counted, and a completion pulse is raised each time the count reaches a programmed level. The count then starts again from zero.

Top module: `hash_ring_fetch`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_ptr` is 0 and `mem_req_valid`, `burst_valid`, `done_pulse` and `len_err` are all 0.
- R2: For slot `rd_ptr`, the block reads exactly four words in the order k = 0, 1, 2, 3 at addresses `ring_base + 16*rd_ptr + 4*k`. Only one read is outstanding at a time, and a request holds its address until `mem_req_ready` is seen.
- R3: The burst address is {word 3, word 1}, the burst length is word 2, `burst_first` is word 0 bit 8 and `burst_last` is word 0 bit 9. Word 0 bits [7:0] and [31:10] have no effect.
- R4: `burst_valid`, once raised, stays high with `burst_addr`, `burst_len`, `burst_first` and `burst_last` unchanged until the cycle in which `burst_ready` is high.
- R5: After each descriptor is finished, `rd_ptr` advances by exactly one and wraps from 126 to 0. A descriptor is finished either when its burst is accepted or when it is dropped for a length error.
- R6: A configuration write whose pointer field is 0 to 126 loads both the write index and the completion level. A write whose pointer field is 127 is ignored entirely.
- R7: A length is rejected if it is 0, or if the descriptor is not a closing one (bit 9 clear) and the length is not a multiple of 64 bytes (`alg_wide`=0) or 128 bytes (`alg_wide`=1). A rejected descriptor produces no burst and is not counted. `len_err` pulses for one cycle, in the same cycle that `rd_ptr` moves on.
- R8: `done_pulse` is high for one cycle, in the cycle after a burst handshake that brings the number of accepted descriptors since the last pulse up to the level. The count then restarts at 0. A level of 0 acts as 1.
- R9: While `rd_ptr` equals the write index, no memory read and no burst is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wptr | input | 7 | Software write index (0 to 126) |
| cfg_level | input | 7 | Descriptors per completion pulse |
| ring_base | input | 64 | Byte address of ring slot 0 |
| alg_wide | input | 1 | 1 selects 128-byte blocks, 0 selects 64-byte blocks |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | 64 | Byte address of the requested word |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| burst_valid | output | 1 | Burst request toward the digest datapath |
| burst_addr | output | 64 | Message address |
| burst_len | output | 32 | Message length in bytes |
| burst_first | output | 1 | Descriptor opens a message |
| burst_last | output | 1 | Descriptor closes a message |
| burst_ready | input | 1 | Datapath accepts the burst |
| done_pulse | output | 1 | Completion-level pulse |
| len_err | output | 1 | Length-rejection pulse |
| rd_ptr | output | 7 | Current read index |

## Verification
The assertions assume that the memory port returns exactly one `mem_rsp_valid` beat for each accepted request, and only while the block is waiting for it. They also assume that `ring_base` and `alg_wide` stay constant while a descriptor is in flight, and that software never posts more than 126 pending slots. The bench honours these assumptions in three ways. Its responder answers one cycle after each accepted request. It changes the base and algorithm only after the model queue has drained. It commits descriptors in batches of at most 40.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned DESC_SHIFT = 4;   // 16 bytes per slot
  localparam int unsigned WORD_SHIFT = 2;   // 4 bytes per word

  typedef enum logic [2:0] {
    FS_IDLE, FS_REQ, FS_WAIT, FS_CHECK, FS_ISSUE
  } fetch_state_t;

  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base,
                                                  logic [ADDR_W-1:0] slot,
                                                  logic [ADDR_W-1:0] widx);
    return base + (slot << DESC_SHIFT) + (widx << WORD_SHIFT);
  endfunction

  function automatic logic len_ok(logic [WORD_W-1:0] len, logic closing, int unsigned blk_lg);
    logic [WORD_W-1:0] mask;
    mask = (WORD_W'(1) << blk_lg) - WORD_W'(1);
    return (len != '0) && (closing || ((len & mask) == '0));
  endfunction

  function automatic logic level_hit(int unsigned cnt, int unsigned lvl);
    int unsigned eff;
    eff = (lvl == 0) ? 1 : lvl;
    return (cnt + 1) >= eff;
  endfunction
endpackage

// File: rtl/hrf_ptr_ctrl.sv
module hrf_ptr_ctrl #(
  parameter int unsigned DEPTH = 127,
  parameter int unsigned LVL_W = 7,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [PTR_W-1:0] cfg_wptr,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             adv,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             pending
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             cfg_take;

  assign cfg_take = cfg_we && (int'(cfg_wptr) < DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= LVL_W'(1);
    end else begin
      if (cfg_take) begin
        wr_q  <= cfg_wptr;
        lvl_q <= cfg_level;
      end
      if (adv) rd_q <= PTR_W'(hrf_pkg::ring_next(int'(rd_q), DEPTH));
    end
  end

  assign rd_ptr  = rd_q;
  assign level   = lvl_q;
  assign pending = (rd_q != wr_q);

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(rd_q) < DEPTH);                                                     // R5
  AST_ADV_PENDING: assert property (@(posedge clk) disable iff (rst)
    adv |-> pending);                                                        // R9
  AST_BAD_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_wptr) >= DEPTH) |=> ($stable(wr_q) && $stable(lvl_q))); // R6
endmodule

// File: rtl/hrf_desc_fetch.sv
module hrf_desc_fetch #(
  parameter int unsigned PTR_W     = 7,
  parameter int unsigned NARROW_LG = 6,
  parameter int unsigned WIDE_LG   = 7,
  localparam int unsigned AW = hrf_pkg::ADDR_W,
  localparam int unsigned WW = hrf_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [AW-1:0]    ring_base,
  input  logic             alg_wide,
  output logic             mem_req_valid,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [WW-1:0]    mem_rsp_data,
  output logic             burst_valid,
  output logic [AW-1:0]    burst_addr,
  output logic [WW-1:0]    burst_len,
  output logic             burst_first,
  output logic             burst_last,
  input  logic             burst_ready,
  output logic             adv,
  output logic             good_fire,
  output logic             len_err
);
  import hrf_pkg::*;

  localparam int unsigned CTRL_LSB  = 8;
  localparam int unsigned FIRST_BIT = CTRL_LSB + 0;
  localparam int unsigned LAST_BIT  = CTRL_LSB + 1;
  localparam int unsigned WIDX_W    = $clog2(DESC_WORDS);

  fetch_state_t      state;
  logic [WIDX_W-1:0] widx;
  logic [WW-1:0]     w_q [DESC_WORDS];
  logic              err_q;
  logic              len_good;
  logic              drop;

  assign len_good = len_ok(w_q[2], w_q[0][LAST_BIT], alg_wide ? WIDE_LG : NARROW_LG);
  assign drop     = (state == FS_CHECK) && !len_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FS_IDLE;
      widx  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        FS_IDLE:  if (pending) begin state <= FS_REQ; widx <= '0; end
        FS_REQ:   if (mem_req_ready) state <= FS_WAIT;
        FS_WAIT:  if (mem_rsp_valid) begin
                    if (widx == WIDX_W'(DESC_WORDS - 1)) state <= FS_CHECK;
                    else begin widx <= widx + 1'b1; state <= FS_REQ; end
                  end
        FS_CHECK: if (len_good) state <= FS_ISSUE;
                  else begin state <= FS_IDLE; err_q <= 1'b1; end
        FS_ISSUE: if (burst_ready) state <= FS_IDLE;
        default:  state <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == FS_WAIT && mem_rsp_valid) w_q[widx] <= mem_rsp_data;
  end

  assign mem_req_valid = (state == FS_REQ);
  assign mem_req_addr  = word_addr(ring_base, AW'(rd_ptr), AW'(widx));
  assign burst_valid   = (state == FS_ISSUE);
  assign burst_addr    = {w_q[3], w_q[1]};
  assign burst_len     = w_q[2];
  assign burst_first   = w_q[0][FIRST_BIT];
  assign burst_last    = w_q[0][LAST_BIT];
  assign good_fire     = burst_valid && burst_ready;
  assign adv           = good_fire || drop;
  assign len_err       = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_valid && burst_valid));                                        // R2
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_addr)
      && $stable(burst_len) && $stable(burst_first) && $stable(burst_last))); // R4
  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !$past(burst_valid));                                        // R7
endmodule

// File: rtl/hrf_done_count.sv
module hrf_done_count #(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             good_fire,
  input  logic [LVL_W-1:0] level,
  output logic             done_pulse
);
  logic [LVL_W-1:0] cnt_q;
  logic             pulse_q;
  logic             hit;

  assign hit = hrf_pkg::level_hit(int'(cnt_q), int'(level));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (good_fire) begin
        if (hit) begin cnt_q <= '0; pulse_q <= 1'b1; end
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_pulse = pulse_q;

  AST_PULSE_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> $past(good_fire));                                        // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);                                             // R8
endmodule

// File: rtl/hash_ring_fetch.sv
module hash_ring_fetch #(
  parameter int unsigned DEPTH     = 127,
  parameter int unsigned LVL_W     = 7,
  parameter int unsigned NARROW_LG = 6,
  parameter int unsigned WIDE_LG   = 7,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [PTR_W-1:0] cfg_wptr,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [63:0]      ring_base,
  input  logic             alg_wide,
  output logic             mem_req_valid,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             burst_valid,
  output logic [63:0]      burst_addr,
  output logic [31:0]      burst_len,
  output logic             burst_first,
  output logic             burst_last,
  input  logic             burst_ready,
  output logic             done_pulse,
  output logic             len_err,
  output logic [PTR_W-1:0] rd_ptr
);
  logic             adv;
  logic             good_fire;
  logic             pending;
  logic [LVL_W-1:0] level;

  hrf_ptr_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ptr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wptr(cfg_wptr),
    .cfg_level(cfg_level), .adv(adv), .rd_ptr(rd_ptr), .level(level),
    .pending(pending));

  hrf_desc_fetch #(.PTR_W(PTR_W), .NARROW_LG(NARROW_LG), .WIDE_LG(WIDE_LG)) u_fetch (
    .clk(clk), .rst(rst), .pending(pending), .rd_ptr(rd_ptr),
    .ring_base(ring_base), .alg_wide(alg_wide),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .burst_valid(burst_valid),
    .burst_addr(burst_addr), .burst_len(burst_len),
    .burst_first(burst_first), .burst_last(burst_last),
    .burst_ready(burst_ready), .adv(adv), .good_fire(good_fire),
    .len_err(len_err));

  hrf_done_count #(.LVL_W(LVL_W)) u_done (
    .clk(clk), .rst(rst), .good_fire(good_fire), .level(level),
    .done_pulse(done_pulse));

  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    !(done_pulse && len_err));                                               // R7
  AST_QUIET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!pending && !burst_valid) |-> !mem_req_valid);                          // R9
endmodule

// File: tb/sim_hash_ring_fetch.sv
module sim_hash_ring_fetch;
  localparam int DEPTH = 127;
  localparam logic [63:0] BASE = 64'h0000_0045_0000_1000;

  typedef struct packed {
    logic [63:0] a;
    logic [31:0] l;
    logic        f;
    logic        la;
    logic        bad;
  } exp_t;

  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [6:0]  cfg_wptr = 0, cfg_level = 1;
  logic [63:0] ring_base = BASE;
  logic        alg_wide = 0;
  logic        mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_rsp_data = 0;
  logic        burst_valid, burst_first, burst_last, burst_ready = 0;
  logic [63:0] burst_addr;
  logic [31:0] burst_len;
  logic        done_pulse, len_err;
  logic [6:0]  rd_ptr;

  hash_ring_fetch u0 (.*);

  always #5 clk = ~clk;

  int   errs = 0, checks = 0, cyc = 0;
  logic [31:0] bmem [0:DEPTH*4-1];
  exp_t q[$];
  int   sw_wptr = 0, lvl = 1, cnt_m = 0;
  bit   exp_done = 0, prev_hs = 0;
  int   prev_rd = 0, wk = 0;
  bit   rsp_pend = 0;
  logic [31:0] pend_data;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic int nxt(int p);
    return (p + 1 >= DEPTH) ? 0 : p + 1;
  endfunction

  // Memory responder: one beat one cycle after each accepted request.
  int mc = 0;
  always @(negedge clk) begin
    if (rsp_pend) begin mem_rsp_valid = 1; mem_rsp_data = pend_data; rsp_pend = 0; end
    else mem_rsp_valid = 0;
    mc++;
    mem_req_ready = (mc % 3) != 0;
    if (!rst && mem_req_valid && mem_req_ready) begin
      chk("R2 addr", mem_req_addr, BASE + 64'(rd_ptr) * 16 + 64'(wk) * 4);
      pend_data = bmem[int'(rd_ptr) * 4 + wk];
      rsp_pend = 1;
      wk = (wk + 1) % 4;
    end
  end

  // Reference model, compared every cycle.
  always @(negedge clk) begin
    bit hs;
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
    burst_ready = (cyc % 4) != 1;
    if (!rst) begin
      if (prev_hs) begin
        chk("R5 step", 64'(rd_ptr), 64'(nxt(prev_rd)));
        chk("R8 pulse", 64'(done_pulse), 64'(exp_done));
        chk("R7 no err", 64'(len_err), 0);
      end else if (len_err) begin
        chk("R7 bad head", 64'(q.size() > 0 ? q[0].bad : 1'b0), 1);
        if (q.size() > 0) void'(q.pop_front());
        chk("R5 step", 64'(rd_ptr), 64'(nxt(prev_rd)));
        chk("R7 no pulse", 64'(done_pulse), 0);
      end else begin
        chk("R5 hold", 64'(rd_ptr), 64'(prev_rd));
        chk("R8 quiet", 64'(done_pulse), 0);
      end
      if (q.size() == 0) begin
        chk("R9 idle req", 64'(mem_req_valid), 0);
        chk("R9 idle burst", 64'(burst_valid), 0);
      end
      hs = burst_valid && burst_ready;
      if (hs) begin
        if (q.size() == 0) chk("R3 unexpected burst", 1, 0);
        else begin
          chk("R7 good head", 64'(q[0].bad), 0);
          chk("R3 addr", burst_addr, q[0].a);
          chk("R3 len", 64'(burst_len), 64'(q[0].l));
          chk("R3 first", 64'(burst_first), 64'(q[0].f));
          chk("R3 last", 64'(burst_last), 64'(q[0].la));
          void'(q.pop_front());
        end
        cnt_m++;
        exp_done = cnt_m >= ((lvl == 0) ? 1 : lvl);
        if (exp_done) cnt_m = 0;
      end
      prev_hs = hs;
      prev_rd = int'(rd_ptr);
    end
  end

  task automatic push(bit f, bit la, logic [63:0] a, logic [31:0] l);
    logic [31:0] w0;
    int blk;
    exp_t e;
    blk = alg_wide ? 128 : 64;
    w0 = {18'h2A5A5 ^ 18'(sw_wptr), 4'(sw_wptr) | 4'b1001, la, f, 6'b101101, 2'(sw_wptr)};
    bmem[sw_wptr*4+0] = w0;
    bmem[sw_wptr*4+1] = a[31:0];
    bmem[sw_wptr*4+2] = l;
    bmem[sw_wptr*4+3] = a[63:32];
    e.a = a; e.l = l; e.f = f; e.la = la;
    e.bad = (l == 0) || (!la && (l % blk) != 0);
    q.push_back(e);
    sw_wptr = nxt(sw_wptr);
  endtask

  task automatic commit(int level_v);
    @(negedge clk);
    lvl = level_v;
    cfg_wptr = 7'(sw_wptr); cfg_level = 7'(level_v); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 rd_ptr", 64'(rd_ptr), 0);
    chk("R1 req", 64'(mem_req_valid), 0);
    chk("R1 burst", 64'(burst_valid), 0);
    chk("R1 done", 64'(done_pulse), 0);
    chk("R1 err", 64'(len_err), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after", 64'(rd_ptr), 0);

    // single-node message, level 1
    push(1, 1, 64'h0000_0001_DEAD_0000, 32'd100);
    commit(1); drain();
    // multi-part message, level 2
    push(1, 0, 64'h0000_0002_0000_0040, 32'd128);
    push(0, 0, 64'h0000_0002_0000_00C0, 32'd192);
    push(0, 1, 64'h0000_0002_0000_0180, 32'd5);
    push(1, 1, 64'hFFFF_0000_1234_5678, 32'd64);
    commit(2); drain();
    // R7 length errors mixed with a good node
    push(0, 0, 64'h10, 32'd100);
    push(1, 0, 64'h20, 32'd0);
    push(0, 1, 64'h30, 32'd0);
    push(0, 0, 64'h40, 32'd64);
    commit(1); drain();
    // R7 wide algorithm block size
    alg_wide = 1;
    push(1, 0, 64'h50, 32'd192);
    push(1, 0, 64'h60, 32'd256);
    push(0, 1, 64'h70, 32'd7);
    commit(1); drain();
    alg_wide = 0;
    // R6: level 3, then an out-of-range write that must change nothing
    commit(3);
    @(negedge clk);
    cfg_wptr = 7'd127; cfg_level = 7'd1; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    repeat (6) @(negedge clk);
    chk("R6 ignored ptr", 64'(rd_ptr), 64'(sw_wptr));
    push(1, 1, 64'h80, 32'd9);
    commit(3); drain();
    push(1, 1, 64'h90, 32'd9);
    push(1, 1, 64'hA0, 32'd9);
    commit(3); drain();
    // R8 level 0 behaves as 1
    push(1, 1, 64'hB0, 32'd1);
    push(1, 1, 64'hC0, 32'd2);
    commit(0); drain();
    // R5 wrap through index 126
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 40; i++)
        push(i[0], i[1], 64'h0000_0300_0000_0000 + 64'(b*4096 + i*64), 32'(64 * (i % 5 + 1)));
      commit(2); drain();
    end
    chk("R5 wrapped", 64'(rd_ptr), 64'(sw_wptr));
    finish_run();
  end
endmodule